// File: doc/BRIEF.md
# Vector Clip Test Unit

This unit carries out the three clip-test operations of a 16-bit, 8-lane vector datapath: a single-word high clip, a single-word range clip, and a low clip that finishes a two-word test. In every lane it compares a source value VS against a bound VT and forms three things: a sign-difference term, a "low" test and a "high" test. From these it picks either VS or a transformed copy of VT (VC, which is VT negated or complemented) as the lane result. The result is written both to the result output and to the accumulator-low output, and a set of five per-lane flag registers is updated.

The flags are clip, compare, not-equal, carry and extension. They connect the operations to each other. The high clip runs on the upper word of a double-precision value and leaves behind its sign term, its equality state and the extension condition. The low clip that follows reads those flags to complete the test on the lower word. The range clip, like the low clip, leaves clean not-equal, carry and extension flags.

Opcodes: 0 = high clip, 1 = low clip, 2 = range clip. Opcode 3 is a no-op.

Top module: `vclip_unit`

## Requirements
- R1: Synchronous active-high reset sets to zero the result, the accumulator-low output and all five flag vectors.
- R2: High clip (opcode 0). For each lane, sn is bit 15 of VS xor VT. VC is -VT when sn is set, otherwise VT; a VT of -32768 stays -32768. The selector is the low test when sn is set, else the high test. The lane result is VC when the selector is set, else VS.
- R3: High clip tests, all signed. When sn is set: low = VS <= VC and high = VT < 0. When sn is clear: low = VT < 0 and high = VS >= VT.
- R4: After a high clip: clip = high, compare = low, carry = sn. Extension = sn and (VS == ~VT). Not-equal is the inverse of ((VS == VC and VT != -32768) or extension).
- R5: For a VT lane of -32768 under the high clip, VC is -32768. The equality term is false unless the extension condition holds.
- R6: Range clip (opcode 2). sn is as in R2. VC is ~VT when sn is set, else VT. When sn is set: low = VT <= ~VS and high = VT < 0. When sn is clear: low = VT < 0 and high = VS >= VT. All comparisons are signed. Selection is as in R2.
- R7: After a range clip: clip = high, compare = low, and not-equal, carry and extension are cleared.
- R8: Low clip (opcode 1). sn = stored carry, eq = inverse of stored not-equal, VC = sn ? -VT : VT (modulo 2^16). lz = (VS == VC). uz = the unsigned 16-bit sum VS+VT has no carry out. When eq and sn are both set, the new low is (lz or uz) if the stored extension is set, else (lz and uz). Otherwise the new low is the stored compare flag.
- R9: Low clip high test and result. When eq is set and sn clear, the new high is unsigned VS >= VC. Otherwise the new high is the stored clip flag. The selector is the new low when sn is set, else the new high. The result is VC when the selector is set, else VS.
- R10: After a low clip: clip = new high, compare = new low, and not-equal, carry and extension are cleared.
- R11: Result and flags change on the clock edge that samples op_valid high with opcode 0, 1 or 2. They hold when op_valid is low or the opcode is 3.
- R12: The accumulator-low output always equals the result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 0 high clip, 1 low clip, 2 range clip, 3 no-op |
| vs_in | input | 128 | VS vector, lane i at bits [16i+15:16i] |
| vt_in | input | 128 | VT vector, same lane layout |
| res_out | output | 128 | Registered result vector |
| acc_lo_out | output | 128 | Registered accumulator-low slice |
| flag_clip | output | 8 | Clip flag per lane |
| flag_cmp | output | 8 | Compare flag per lane |
| flag_ne | output | 8 | Not-equal flag per lane |
| flag_co | output | 8 | Carry (sign) flag per lane |
| flag_ext | output | 8 | Compare-extension flag per lane |

## Verification
A high clip followed by a low clip on the very next cycle is the case where two functions meet in one cycle. On that edge the low clip reads the carry, not-equal and extension flags that the high clip wrote on the previous edge. In the same cycle it overwrites those flags and the result. The bench issues the two operations back to back with no idle cycle and picks lane pairs that reach each branch of the low-clip rules. It then compares every flag and result lane against an independent model that has carried the high-clip flags forward.

// File: rtl/vclip_pkg.sv
package vclip_pkg;
  typedef enum logic [1:0] {
    OP_HIGH  = 2'd0,
    OP_LOW   = 2'd1,
    OP_RANGE = 2'd2,
    OP_NONE  = 2'd3
  } clip_op_e;
endpackage

// File: rtl/vclip_lane.sv
module vclip_lane
  import vclip_pkg::*;
#(
  parameter int W = 16
) (
  input  clip_op_e       op,
  input  logic [W-1:0]   vs,
  input  logic [W-1:0]   vt,
  input  logic           clip_i,
  input  logic           cmp_i,
  input  logic           ne_i,
  input  logic           co_i,
  input  logic           ext_i,
  output logic [W-1:0]   res,
  output logic           clip_o,
  output logic           cmp_o,
  output logic           ne_o,
  output logic           co_o,
  output logic           ext_o
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] s, t, vc, neg_t;
  logic [W:0]          sum;
  logic                sn_x, tmin, sn, eq, lo, hi, sel, ext_n, lz, uz;

  assign s     = vs;
  assign t     = vt;
  assign neg_t = -t;
  assign sn_x  = vs[W-1] ^ vt[W-1];
  assign tmin  = (vt == MINV);
  assign sum   = {1'b0, vs} + {1'b0, vt};

  always_comb begin
    vc     = t;
    sn     = 1'b0;
    eq     = 1'b0;
    lo     = cmp_i;
    hi     = clip_i;
    ext_n  = 1'b0;
    lz     = 1'b0;
    uz     = 1'b0;
    clip_o = clip_i;
    cmp_o  = cmp_i;
    ne_o   = ne_i;
    co_o   = co_i;
    ext_o  = ext_i;
    unique case (op)
      OP_HIGH: begin
        sn     = sn_x;
        vc     = (sn && !tmin) ? neg_t : t;
        ext_n  = sn && (vs == ~vt);
        eq     = ((s == vc) && !tmin) || ext_n;
        lo     = sn ? (s <= vc) : vt[W-1];
        hi     = sn ? vt[W-1] : (s >= t);
        clip_o = hi;
        cmp_o  = lo;
        ne_o   = !eq;
        co_o   = sn;
        ext_o  = ext_n;
      end
      OP_RANGE: begin
        sn     = sn_x;
        vc     = sn ? ~t : t;
        lo     = sn ? (t <= ~s) : vt[W-1];
        hi     = sn ? vt[W-1] : (s >= t);
        clip_o = hi;
        cmp_o  = lo;
        ne_o   = 1'b0;
        co_o   = 1'b0;
        ext_o  = 1'b0;
      end
      OP_LOW: begin
        sn     = co_i;
        eq     = !ne_i;
        vc     = sn ? neg_t : t;
        lz     = (s == vc);
        uz     = !sum[W];
        lo     = (eq && sn) ? (ext_i ? (lz || uz) : (lz && uz)) : cmp_i;
        hi     = (eq && !sn) ? ($unsigned(s) >= $unsigned(vc)) : clip_i;
        clip_o = hi;
        cmp_o  = lo;
        ne_o   = 1'b0;
        co_o   = 1'b0;
        ext_o  = 1'b0;
      end
      default: ;
    endcase
    sel = sn ? lo : hi;
    res = sel ? vc : s;
  end
endmodule

// File: rtl/vclip_state.sv
module vclip_state #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [LANES*W-1:0]   res_n,
  input  logic [LANES-1:0]     clip_n,
  input  logic [LANES-1:0]     cmp_n,
  input  logic [LANES-1:0]     ne_n,
  input  logic [LANES-1:0]     co_n,
  input  logic [LANES-1:0]     ext_n,
  output logic [LANES*W-1:0]   res_q,
  output logic [LANES*W-1:0]   acc_q,
  output logic [LANES-1:0]     clip_q,
  output logic [LANES-1:0]     cmp_q,
  output logic [LANES-1:0]     ne_q,
  output logic [LANES-1:0]     co_q,
  output logic [LANES-1:0]     ext_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      acc_q  <= '0;
      clip_q <= '0;
      cmp_q  <= '0;
      ne_q   <= '0;
      co_q   <= '0;
      ext_q  <= '0;
    end else if (load) begin
      res_q  <= res_n;
      acc_q  <= res_n;
      clip_q <= clip_n;
      cmp_q  <= cmp_n;
      ne_q   <= ne_n;
      co_q   <= co_n;
      ext_q  <= ext_n;
    end
  end
endmodule

// File: rtl/vclip_unit.sv
module vclip_unit
  import vclip_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [1:0]           op_code,
  input  logic [LANES*W-1:0]   vs_in,
  input  logic [LANES*W-1:0]   vt_in,
  output logic [LANES*W-1:0]   res_out,
  output logic [LANES*W-1:0]   acc_lo_out,
  output logic [LANES-1:0]     flag_clip,
  output logic [LANES-1:0]     flag_cmp,
  output logic [LANES-1:0]     flag_ne,
  output logic [LANES-1:0]     flag_co,
  output logic [LANES-1:0]     flag_ext
);
  clip_op_e             op;
  logic                 load;
  logic [LANES*W-1:0]   res_n;
  logic [LANES-1:0]     clip_n, cmp_n, ne_n, co_n, ext_n;

  assign op   = clip_op_e'(op_code);
  assign load = op_valid && (op != OP_NONE);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vclip_lane #(.W(W)) u_lane (
      .op     (op),
      .vs     (vs_in[i*W +: W]),
      .vt     (vt_in[i*W +: W]),
      .clip_i (flag_clip[i]),
      .cmp_i  (flag_cmp[i]),
      .ne_i   (flag_ne[i]),
      .co_i   (flag_co[i]),
      .ext_i  (flag_ext[i]),
      .res    (res_n[i*W +: W]),
      .clip_o (clip_n[i]),
      .cmp_o  (cmp_n[i]),
      .ne_o   (ne_n[i]),
      .co_o   (co_n[i]),
      .ext_o  (ext_n[i])
    );
  end

  vclip_state #(.LANES(LANES), .W(W)) u_state (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .res_n  (res_n),
    .clip_n (clip_n),
    .cmp_n  (cmp_n),
    .ne_n   (ne_n),
    .co_n   (co_n),
    .ext_n  (ext_n),
    .res_q  (res_out),
    .acc_q  (acc_lo_out),
    .clip_q (flag_clip),
    .cmp_q  (flag_cmp),
    .ne_q   (flag_ne),
    .co_q   (flag_co),
    .ext_q  (flag_ext)
  );
endmodule

// File: rtl/vclip_chk.sv
module vclip_chk #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [1:0]           op_code,
  input logic [LANES*W-1:0]   res_out,
  input logic [LANES*W-1:0]   acc_lo_out,
  input logic [LANES-1:0]     flag_clip,
  input logic [LANES-1:0]     flag_cmp,
  input logic [LANES-1:0]     flag_ne,
  input logic [LANES-1:0]     flag_co,
  input logic [LANES-1:0]     flag_ext
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_out == '0 && flag_clip == '0 && flag_cmp == '0 &&
             flag_ne == '0 && flag_co == '0 && flag_ext == '0));

  a_r4_ext_means_equal: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd0) |=> ((flag_ext & flag_ne) == '0));

  a_r4_ext_needs_sign: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd0) |=> ((flag_ext & ~flag_co) == '0));

  a_r7_range_clears: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd2) |=> (flag_ne == '0 && flag_co == '0 && flag_ext == '0));

  a_r10_low_clears: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'd1) |=> (flag_ne == '0 && flag_co == '0 && flag_ext == '0));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_code != 2'd3) |=>
      ($stable(res_out) && $stable(flag_clip) && $stable(flag_cmp) &&
       $stable(flag_ne) && $stable(flag_co) && $stable(flag_ext)));

  a_r12_acc_mirror: assert property (@(posedge clk) disable iff (rst)
    !rst |-> (acc_lo_out == res_out));
endmodule

bind vclip_unit vclip_chk #(.LANES(LANES), .W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .res_out    (res_out),
  .acc_lo_out (acc_lo_out),
  .flag_clip  (flag_clip),
  .flag_cmp   (flag_cmp),
  .flag_ne    (flag_ne),
  .flag_co    (flag_co),
  .flag_ext   (flag_ext)
);

// File: tb/tb_vclip_unit.sv
`timescale 1ns/1ps
module tb_vclip_unit;
  localparam int LANES = 8;
  localparam int W     = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 op_valid = 1'b0;
  logic [1:0]           op_code = 2'd0;
  logic [LANES*W-1:0]   vs_in = '0, vt_in = '0;
  logic [LANES*W-1:0]   res_out, acc_lo_out;
  logic [LANES-1:0]     flag_clip, flag_cmp, flag_ne, flag_co, flag_ext;

  always #5 clk = ~clk;

  vclip_unit #(.LANES(LANES), .W(W)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .vs_in(vs_in), .vt_in(vt_in), .res_out(res_out), .acc_lo_out(acc_lo_out),
    .flag_clip(flag_clip), .flag_cmp(flag_cmp), .flag_ne(flag_ne),
    .flag_co(flag_co), .flag_ext(flag_ext)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  int m_res[LANES];
  bit m_clip[LANES], m_cmp[LANES], m_ne[LANES], m_co[LANES], m_ext[LANES];

  function automatic int wrap16(int x);
    int y;
    y = x & 32'hFFFF;
    return (y >= 32768) ? y - 65536 : y;
  endfunction

  function automatic logic [LANES*W-1:0] pack(input int v[LANES]);
    logic [LANES*W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*W +: W] = v[i][W-1:0];
    return r;
  endfunction

  task automatic model_step(input int op, input int a[LANES], input int b[LANES]);
    for (int i = 0; i < LANES; i++) begin
      bit sn, eq, lo, hi, ext, lz, uz;
      int vc;
      if (op == 0) begin
        sn  = (a[i] < 0) != (b[i] < 0);
        vc  = sn ? ((b[i] == -32768) ? -32768 : -b[i]) : b[i];
        ext = sn && (a[i] == -b[i] - 1);
        eq  = (a[i] == vc && b[i] != -32768) || ext;
        lo  = sn ? (a[i] <= vc) : (b[i] < 0);
        hi  = sn ? (b[i] < 0) : (a[i] >= b[i]);
        m_ne[i] = !eq; m_co[i] = sn; m_ext[i] = ext;
      end else if (op == 2) begin
        sn = (a[i] < 0) != (b[i] < 0);
        vc = sn ? (-b[i] - 1) : b[i];
        lo = sn ? (b[i] <= -a[i] - 1) : (b[i] < 0);
        hi = sn ? (b[i] < 0) : (a[i] >= b[i]);
        m_ne[i] = 0; m_co[i] = 0; m_ext[i] = 0;
      end else begin
        sn = m_co[i];
        eq = !m_ne[i];
        vc = sn ? wrap16(-b[i]) : b[i];
        lz = (a[i] == vc);
        uz = ((a[i] & 32'hFFFF) + (b[i] & 32'hFFFF)) < 65536;
        lo = (eq && sn) ? (m_ext[i] ? (lz || uz) : (lz && uz)) : m_cmp[i];
        hi = (eq && !sn) ? ((a[i] & 32'hFFFF) >= (vc & 32'hFFFF)) : m_clip[i];
        m_ne[i] = 0; m_co[i] = 0; m_ext[i] = 0;
      end
      m_clip[i] = hi;
      m_cmp[i]  = lo;
      m_res[i]  = (sn ? lo : hi) ? vc : a[i];
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [LANES*W-1:0] act,
                     input logic [LANES*W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tres, input string tflag);
    logic [LANES*W-1:0] er;
    logic [LANES-1:0] ec, ep, en, eo, ee;
    for (int i = 0; i < LANES; i++) begin
      er[i*W +: W] = m_res[i][W-1:0];
      ec[i] = m_clip[i]; ep[i] = m_cmp[i]; en[i] = m_ne[i];
      eo[i] = m_co[i];   ee[i] = m_ext[i];
    end
    chk(tres,  "result", res_out, er);
    chk("R12", "acc_lo", acc_lo_out, er);
    chk(tflag, "clip", {{(LANES*W-LANES){1'b0}}, flag_clip}, {{(LANES*W-LANES){1'b0}}, ec});
    chk(tflag, "cmp",  {{(LANES*W-LANES){1'b0}}, flag_cmp},  {{(LANES*W-LANES){1'b0}}, ep});
    chk(tflag, "ne",   {{(LANES*W-LANES){1'b0}}, flag_ne},   {{(LANES*W-LANES){1'b0}}, en});
    chk(tflag, "co",   {{(LANES*W-LANES){1'b0}}, flag_co},   {{(LANES*W-LANES){1'b0}}, eo});
    chk(tflag, "ext",  {{(LANES*W-LANES){1'b0}}, flag_ext},  {{(LANES*W-LANES){1'b0}}, ee});
  endtask

  task automatic drive(input int op, input int a[LANES], input int b[LANES]);
    op_valid = 1'b1;
    op_code  = op[1:0];
    vs_in    = pack(a);
    vt_in    = pack(b);
    if (op != 3) model_step(op, a, b);
  endtask

  task automatic run_op(input int op, input int a[LANES], input int b[LANES],
                        input string tres, input string tflag);
    @(negedge clk);
    drive(op, a, b);
    @(negedge clk);
    op_valid = 1'b0;
    check_all(tres, tflag);
  endtask

  // R1: reset state
  task automatic t_reset();
    for (int i = 0; i < LANES; i++) begin
      m_res[i] = 0; m_clip[i] = 0; m_cmp[i] = 0; m_ne[i] = 0; m_co[i] = 0; m_ext[i] = 0;
    end
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", "R1");
  endtask

  // R2, R3, R4 on mixed signs
  task automatic t_high_basic();
    run_op(0, '{100, 50, -5, 5, 3, -1, 0, 32767},
              '{50, 100, 5, -5, -4, 1, 0, -32767}, "R2", "R4");
    run_op(0, '{-200, 7, -7, 1000, -1000, 2, -3, 12},
              '{-100, -8, 6, 999, 999, -3, -3, -12}, "R3", "R4");
  endtask

  // R5: VT = -32768 lanes
  task automatic t_high_min();
    run_op(0, '{0, -32768, 32767, 1, -1, 5, 32767, -2},
              '{-32768, -32768, -32768, -32768, -32768, -32768, 32767, -32768}, "R5", "R5");
  endtask

  // R6, R7
  task automatic t_range();
    run_op(2, '{100, -100, 5, -5, 3, 0, -32768, 32767},
              '{50, 50, -5, 5, -4, -1, 32767, -32768}, "R6", "R7");
    run_op(2, '{-1, 1, 20, -20, 0, 0, 7, -7},
              '{0, -1, -21, 19, 0, 5, -8, 6}, "R6", "R7");
  endtask

  // High clip then low clip on back-to-back cycles: R8, R9, R10
  task automatic t_double();
    @(negedge clk);
    drive(0, '{0, 5, 7, 3, -2, 1, -3, 100},
             '{-1, -5, 3, 3, -2, -2, 4, -100});
    @(negedge clk);
    check_all("R2", "R4");
    drive(1, '{10, 0, -1, 5, 40000 - 65536, -1, 3, 0},
             '{20, 0, 1, 5, 100, 1, 7, 0});
    @(negedge clk);
    op_valid = 1'b0;
    check_all("R9", "R8");
    @(negedge clk);
    drive(0, '{1, -1, 6, 9, -32768, 4, 2, -9},
             '{-2, 1, -6, 9, 32767, 4, 3, 9});
    @(negedge clk);
    check_all("R2", "R4");
    drive(1, '{-32768, 1, 6, 8, 0, 4, 2, -1},
             '{-32768, -1, 10, 9, 1, 4, 3, -1});
    @(negedge clk);
    op_valid = 1'b0;
    check_all("R9", "R10");
  endtask

  // low clip after range clip (carry/ne cleared): R8, R9
  task automatic t_low_after_range();
    run_op(2, '{1, 2, 3, 4, 5, 6, 7, 8}, '{1, 3, 2, 4, -5, 6, -7, 9}, "R6", "R7");
    run_op(1, '{10, -1, 0, 5, 3, 32767, -32768, 0},
              '{9, 1, 0, 6, -3, -1, 32767, -1}, "R9", "R8");
  endtask

  // R11: idle cycles and opcode 3 leave state alone
  task automatic t_hold();
    @(negedge clk);
    op_valid = 1'b0;
    op_code  = 2'd0;
    vs_in    = {LANES{16'h1234}};
    vt_in    = {LANES{16'hF00D}};
    repeat (2) @(negedge clk);
    check_all("R11", "R11");
    run_op(3, '{9, 9, 9, 9, 9, 9, 9, 9}, '{-9, -9, -9, -9, -9, -9, -9, -9}, "R11", "R11");
  endtask

  initial begin
    t_reset();
    t_high_basic();
    t_high_min();
    t_range();
    t_double();
    t_low_after_range();
    t_hold();
    t_reset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule